// File: doc/BRIEF.md
# Control Register Mode Tracker

This block keeps the processor's mode-control state: the main control word (CR0), the page-table base (CR3), the feature-enable word (CR4) and the extended-feature word (EFER). Next to these registers it keeps a packed vector of derived mode flags that the rest of the pipeline reads instead of decoding the control words again. One register is written per cycle through a write strobe, a 2-bit select and a 32-bit data bus. The stored value and every flag that depends on it take effect at the same clock edge.

Some writes make the translation caches stale. For those writes the block raises a one-cycle flush request. It also handles the switch into and out of the 64-bit long mode. When paging is turned on while long mode is enabled, long mode becomes active. When paging is turned off while long mode is active, long mode is dropped and a one-cycle program-counter truncate pulse is sent. An input tells the block whether streaming-SIMD state saving is supported. When it is not, the matching CR4 enable bit cannot be set.

Top module: `ctrl_mode_tracker`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) loads CR0 = 0x60000010 and clears CR3, CR4 and EFER. It sets `mode_flags` = 0x02 (only the address-add-segment flag set) and holds both pulses low.
- R2: Every accepted CR0 write stores the data with bit 4 forced to 1.
- R3: A CR0 write whose data differs from the stored CR0 in bit 31 (paging), bit 16 (write-protect) or bit 0 (protection) raises `flush_pulse`. A write that changes none of these bits does not.
- R4: A CR0 write that sets bit 31 while stored bit 31 is clear, EFER bit 8 (long-mode enable) is set and CR4 bit 5 (PAE) is set activates long mode. The write sets `mode_flags` bit 5 and EFER bit 10. If EFER bit 8 is clear, paging turns on without long mode.
- R5: A CR0 write that would activate long mode while CR4 bit 5 is clear is refused. CR0, EFER and `mode_flags` keep their values and no flush pulse is raised.
- R6: A CR0 write that clears bit 31 while long mode is active clears `mode_flags` bits 5 and 6 and EFER bit 10, and raises `pc_trunc_pulse`.
- R7: `mode_flags` bit 0 follows CR0 bit 0. Bit 1 (address-add-segment) is set whenever CR0 bit 0 is clear and, once set, stays set.
- R8: On each accepted CR0 write, `mode_flags` bits 2, 3 and 4 take CR0 bits 1, 2 and 3.
- R9: A CR4 write that changes bit 7, bit 5 or bit 4 raises `flush_pulse`. A write that changes none of these bits does not.
- R10: With `simd_cap` low, a CR4 write stores bit 9 as 0. `mode_flags` bit 7 follows the stored CR4 bit 9.
- R11: A CR3 write stores the data. It raises `flush_pulse` only when CR0 bit 31 is set.
- R12: `wr_sel` selects 00 = CR0, 01 = CR3, 10 = CR4, 11 = EFER, and nothing changes while `wr_en` is low. An EFER write stores the data except bit 10, which keeps its value.
- R13: `flush_pulse` and `pc_trunc_pulse` are registered. Each is high only in the cycle after the write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target register of the write |
| wr_data | input | 32 | Write data |
| simd_cap | input | 1 | Streaming-SIMD state saving is supported |
| cr0_q | output | 32 | Stored CR0 |
| cr3_q | output | 32 | Stored CR3 |
| cr4_q | output | 32 | Stored CR4 |
| efer_q | output | 32 | Stored EFER |
| mode_flags | output | 8 | Derived flags: 0 protected, 1 add-segment, 2 MP, 3 EM, 4 TS, 5 long mode active, 6 64-bit code, 7 OS state-save enabled |
| flush_pulse | output | 1 | One-cycle translation flush request |
| pc_trunc_pulse | output | 1 | One-cycle program-counter truncate request |

## Verification
The hardest states to reach are the refused long-mode entry and the long-mode exit. Each needs a particular order of writes: EFER enable set, then CR4 PAE set or cleared, and only then CR0 paging turned on. A directed sequence builds each order in turn, and then turns paging off again while long mode is active. A random phase follows. It mixes writes to all four registers, with `simd_cap` chosen at random for each cycle, and a behavioural model is compared against every output on every clock. Paging, long-mode enable and PAE are each set about half the time, so the phase reaches entry, refusal and exit many times.

// File: rtl/crmode_pkg.sv
package crmode_pkg;
  localparam int CR_W = 32;
  typedef logic [CR_W-1:0] creg_t;

  // CR0 bit positions
  localparam int B_PE = 0;
  localparam int B_MP = 1;
  localparam int B_EM = 2;
  localparam int B_TS = 3;
  localparam int B_ET = 4;
  localparam int B_WP = 16;
  localparam int B_PG = 31;
  // CR4 bit positions
  localparam int B4_PSE  = 4;
  localparam int B4_PAE  = 5;
  localparam int B4_PGE  = 7;
  localparam int B4_FXSR = 9;
  // EFER bit positions
  localparam int BE_LME = 8;
  localparam int BE_LMA = 10;

  localparam creg_t CR0_RESET = 32'h6000_0010;
  localparam creg_t CR0_FLUSH_M = (creg_t'(1) << B_PG) | (creg_t'(1) << B_WP) | (creg_t'(1) << B_PE);
  localparam creg_t CR4_FLUSH_M = (creg_t'(1) << B4_PGE) | (creg_t'(1) << B4_PAE) | (creg_t'(1) << B4_PSE);

  typedef enum logic [1:0] {
    SEL_CR0  = 2'b00,
    SEL_CR3  = 2'b01,
    SEL_CR4  = 2'b10,
    SEL_EFER = 2'b11
  } wsel_e;

  // Packed mode flags, pe lands in bit 0
  typedef struct packed {
    logic osfxsr;
    logic cs64;
    logic lma;
    logic ts;
    logic em;
    logic mp;
    logic addseg;
    logic pe;
  } mflags_t;

  localparam int FLAG_W = $bits(mflags_t);

  function automatic logic masked_diff(creg_t a, creg_t b, creg_t m);
    return |((a ^ b) & m);
  endfunction

  // Flags that a stored CR0 value implies; long-mode bits untouched
  function automatic mflags_t cr0_flags(mflags_t cur, creg_t cr0);
    mflags_t f;
    f        = cur;
    f.pe     = cr0[B_PE];
    f.addseg = cur.addseg | ~cr0[B_PE];
    f.mp     = cr0[B_MP];
    f.em     = cr0[B_EM];
    f.ts     = cr0[B_TS];
    return f;
  endfunction
endpackage

// File: rtl/crmode_cr0_path.sv
module crmode_cr0_path
  import crmode_pkg::*;
(
  input  creg_t cur_cr0,
  input  creg_t wdata,
  input  logic  lme,
  input  logic  lma,
  input  logic  pae,
  output creg_t nxt_cr0,
  output logic  flush_req,
  output logic  enter_lm,
  output logic  leave_lm,
  output logic  refuse
);
  logic pg_on, pg_off;

  always_comb begin
    pg_on     = ~cur_cr0[B_PG] & wdata[B_PG];
    pg_off    = cur_cr0[B_PG] & ~wdata[B_PG];
    enter_lm  = pg_on & lme & pae;
    refuse    = pg_on & lme & ~pae;
    leave_lm  = pg_off & lma;
    nxt_cr0   = refuse ? cur_cr0 : (wdata | (creg_t'(1) << B_ET));
    flush_req = ~refuse & masked_diff(cur_cr0, wdata, CR0_FLUSH_M);
  end
endmodule

// File: rtl/crmode_cr4_path.sv
module crmode_cr4_path
  import crmode_pkg::*;
(
  input  creg_t cur_cr4,
  input  creg_t wdata,
  input  logic  simd_cap,
  output creg_t nxt_cr4,
  output logic  flush_req
);
  always_comb begin
    nxt_cr4   = simd_cap ? wdata : (wdata & ~(creg_t'(1) << B4_FXSR));
    flush_req = masked_diff(cur_cr4, wdata, CR4_FLUSH_M);
  end
endmodule

// File: rtl/ctrl_mode_tracker.sv
module ctrl_mode_tracker
  import crmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CR_W-1:0]   wr_data,
  input  logic              simd_cap,
  output logic [CR_W-1:0]   cr0_q,
  output logic [CR_W-1:0]   cr3_q,
  output logic [CR_W-1:0]   cr4_q,
  output logic [CR_W-1:0]   efer_q,
  output logic [FLAG_W-1:0] mode_flags,
  output logic              flush_pulse,
  output logic              pc_trunc_pulse
);
  creg_t   cr0_r, cr3_r, cr4_r, efer_r;
  creg_t   cr0_nx, cr3_nx, cr4_nx, efer_nx;
  creg_t   cr0_cand, cr4_cand;
  mflags_t flags_r, flags_nx;
  logic    flush_nx, trunc_nx;

  // Named internal events, observed by the checker
  logic ev_cr0_wr, ev_cr3_wr, ev_cr4_wr, ev_efer_wr;
  logic ev_enter, ev_leave, ev_refuse;
  logic cr0_flush, cr4_flush;

  always_comb begin
    ev_cr0_wr  = wr_en & (wsel_e'(wr_sel) == SEL_CR0);
    ev_cr3_wr  = wr_en & (wsel_e'(wr_sel) == SEL_CR3);
    ev_cr4_wr  = wr_en & (wsel_e'(wr_sel) == SEL_CR4);
    ev_efer_wr = wr_en & (wsel_e'(wr_sel) == SEL_EFER);
  end

  logic enter_raw, leave_raw, refuse_raw;

  crmode_cr0_path u_cr0 (
    .cur_cr0   (cr0_r),
    .wdata     (wr_data),
    .lme       (efer_r[BE_LME]),
    .lma       (flags_r.lma),
    .pae       (cr4_r[B4_PAE]),
    .nxt_cr0   (cr0_cand),
    .flush_req (cr0_flush),
    .enter_lm  (enter_raw),
    .leave_lm  (leave_raw),
    .refuse    (refuse_raw)
  );

  crmode_cr4_path u_cr4 (
    .cur_cr4   (cr4_r),
    .wdata     (wr_data),
    .simd_cap  (simd_cap),
    .nxt_cr4   (cr4_cand),
    .flush_req (cr4_flush)
  );

  always_comb begin
    ev_enter  = ev_cr0_wr & enter_raw;
    ev_leave  = ev_cr0_wr & leave_raw;
    ev_refuse = ev_cr0_wr & refuse_raw;

    cr0_nx   = cr0_r;
    cr3_nx   = cr3_r;
    cr4_nx   = cr4_r;
    efer_nx  = efer_r;
    flags_nx = flags_r;
    flush_nx = 1'b0;
    trunc_nx = 1'b0;

    if (ev_cr0_wr && !refuse_raw) begin
      cr0_nx   = cr0_cand;
      flags_nx = cr0_flags(flags_r, cr0_cand);
      flush_nx = cr0_flush;
      if (enter_raw) begin
        flags_nx.lma   = 1'b1;
        efer_nx[BE_LMA] = 1'b1;
      end else if (leave_raw) begin
        flags_nx.lma   = 1'b0;
        flags_nx.cs64  = 1'b0;
        efer_nx[BE_LMA] = 1'b0;
        trunc_nx       = 1'b1;
      end
    end
    if (ev_cr3_wr) begin
      cr3_nx   = wr_data;
      flush_nx = cr0_r[B_PG];
    end
    if (ev_cr4_wr) begin
      cr4_nx          = cr4_cand;
      flags_nx.osfxsr = cr4_cand[B4_FXSR];
      flush_nx        = cr4_flush;
    end
    if (ev_efer_wr) begin
      efer_nx         = wr_data;
      efer_nx[BE_LMA] = efer_r[BE_LMA];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr0_r          <= CR0_RESET;
      cr3_r          <= '0;
      cr4_r          <= '0;
      efer_r         <= '0;
      flags_r        <= cr0_flags(mflags_t'('0), CR0_RESET);
      flush_pulse    <= 1'b0;
      pc_trunc_pulse <= 1'b0;
    end else begin
      cr0_r          <= cr0_nx;
      cr3_r          <= cr3_nx;
      cr4_r          <= cr4_nx;
      efer_r         <= efer_nx;
      flags_r        <= flags_nx;
      flush_pulse    <= flush_nx;
      pc_trunc_pulse <= trunc_nx;
    end
  end

  assign cr0_q      = cr0_r;
  assign cr3_q      = cr3_r;
  assign cr4_q      = cr4_r;
  assign efer_q     = efer_r;
  assign mode_flags = flags_r;
endmodule

// File: rtl/crmode_chk.sv
module crmode_chk
  import crmode_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [CR_W-1:0]   wr_data,
  input logic [CR_W-1:0]   cr0_q,
  input logic [CR_W-1:0]   cr4_q,
  input logic [CR_W-1:0]   efer_q,
  input logic [FLAG_W-1:0] mode_flags,
  input logic              flush_pulse,
  input logic              pc_trunc_pulse,
  input logic              ev_enter,
  input logic              ev_refuse
);
  AST_ET_SET: assert property (@(posedge clk) disable iff (rst) cr0_q[B_ET]); // R2
  AST_PE_MIRROR: assert property (@(posedge clk) disable iff (rst) mode_flags[0] == cr0_q[B_PE]); // R7
  AST_ADDSEG_REAL: assert property (@(posedge clk) disable iff (rst) !cr0_q[B_PE] |-> mode_flags[1]); // R7
  AST_OSFXSR_FOLLOW: assert property (@(posedge clk) disable iff (rst) mode_flags[7] == cr4_q[B4_FXSR]); // R10
  AST_LMA_AGREE: assert property (@(posedge clk) disable iff (rst) mode_flags[5] == efer_q[BE_LMA]); // R4
  AST_ENTER_LMA: assert property (@(posedge clk) disable iff (rst) ev_enter |=> mode_flags[5]); // R4
  AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ev_refuse |=> $stable(cr0_q) && $stable(mode_flags) && !flush_pulse); // R5
  AST_TRUNC_EXIT: assert property (@(posedge clk) disable iff (rst)
    pc_trunc_pulse |-> !mode_flags[5] && !mode_flags[6] && !cr0_q[B_PG]); // R6
  AST_CR3_FLUSH: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel == 2'b01 && cr0_q[B_PG] |=> flush_pulse); // R11
  AST_PG_OFF_FLUSH: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel == 2'b00 && cr0_q[B_PG] && !wr_data[B_PG] |=> flush_pulse); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !flush_pulse && !pc_trunc_pulse && $stable(cr0_q)); // R13
endmodule

bind ctrl_mode_tracker crmode_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_en          (wr_en),
  .wr_sel         (wr_sel),
  .wr_data        (wr_data),
  .cr0_q          (cr0_q),
  .cr4_q          (cr4_q),
  .efer_q         (efer_q),
  .mode_flags     (mode_flags),
  .flush_pulse    (flush_pulse),
  .pc_trunc_pulse (pc_trunc_pulse),
  .ev_enter       (ev_enter),
  .ev_refuse      (ev_refuse)
);

// File: tb/test_ctrl_mode_tracker.sv
module test_ctrl_mode_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'b00;
  logic [31:0] wr_data = '0;
  logic        simd_cap = 1'b0;
  logic [31:0] cr0_q, cr3_q, cr4_q, efer_q;
  logic [7:0]  mode_flags;
  logic        flush_pulse, pc_trunc_pulse;

  int checks = 0;
  int failures = 0;

  ctrl_mode_tracker i_ctrl_mode_tracker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .simd_cap(simd_cap), .cr0_q(cr0_q), .cr3_q(cr3_q), .cr4_q(cr4_q),
    .efer_q(efer_q), .mode_flags(mode_flags), .flush_pulse(flush_pulse),
    .pc_trunc_pulse(pc_trunc_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [31:0] m_cr0, m_cr3, m_cr4, m_efer;
  logic [7:0]  m_fl;
  logic        m_flush, m_trunc;
  bit          m_live = 0;

  always @(posedge clk) begin
    logic [31:0] d;
    logic turning_on, turning_off;
    d = wr_data;
    m_flush = 0;
    m_trunc = 0;
    if (rst) begin
      m_cr0 = 32'h6000_0010; m_cr3 = 0; m_cr4 = 0; m_efer = 0; m_fl = 8'h02;
      m_live = 1;
    end else if (wr_en) begin
      if (wr_sel == 2'd0) begin
        turning_on  = !m_cr0[31] && d[31];
        turning_off = m_cr0[31] && !d[31];
        if (!(turning_on && m_efer[8] && !m_cr4[5])) begin
          m_flush = (m_cr0[31] != d[31]) || (m_cr0[16] != d[16]) || (m_cr0[0] != d[0]);
          if (turning_on && m_efer[8]) begin m_fl[5] = 1; m_efer[10] = 1; end
          if (turning_off && m_fl[5]) begin
            m_fl[5] = 0; m_fl[6] = 0; m_efer[10] = 0; m_trunc = 1;
          end
          m_cr0 = d;
          m_cr0[4] = 1'b1;
          m_fl[0] = d[0];
          if (!d[0]) m_fl[1] = 1;
          m_fl[4:2] = d[3:1];
        end
      end else if (wr_sel == 2'd1) begin
        m_cr3 = d;
        m_flush = m_cr0[31];
      end else if (wr_sel == 2'd2) begin
        m_flush = (m_cr4[7] != d[7]) || (m_cr4[5] != d[5]) || (m_cr4[4] != d[4]);
        m_cr4 = d;
        if (!simd_cap) m_cr4[9] = 0;
        m_fl[7] = m_cr4[9];
      end else begin
        m_efer = {d[31:11], m_efer[10], d[9:0]};
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (m_live && !rst) begin
      chk("R2 cr0 model",   cr0_q, m_cr0);
      chk("R11 cr3 model",  cr3_q, m_cr3);
      chk("R10 cr4 model",  cr4_q, m_cr4);
      chk("R12 efer model", efer_q, m_efer);
      chk("R7 flags model", {24'h0, mode_flags}, {24'h0, m_fl});
      chk("R3 flush model", {31'h0, flush_pulse}, {31'h0, m_flush});
      chk("R6 trunc model", {31'h0, pc_trunc_pulse}, {31'h0, m_trunc});
    end
  end

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 cr0",  cr0_q, 32'h6000_0010);
    chk("R1 cr3",  cr3_q, 0);
    chk("R1 cr4",  cr4_q, 0);
    chk("R1 efer", efer_q, 0);
    chk("R1 flags", {24'h0, mode_flags}, 32'h02);
    chk("R1 pulses", {30'h0, flush_pulse, pc_trunc_pulse}, 0);

    wr(2'd0, 32'h0);
    chk("R2 et forced", cr0_q, 32'h10);
    chk("R3 no flush other bits", {31'h0, flush_pulse}, 0);
    wr(2'd0, 32'h0000_000F);
    chk("R3 flush on pe", {31'h0, flush_pulse}, 1);
    chk("R8 mp em ts", {24'h0, mode_flags}, 32'h1F);
    idle();
    chk("R13 flush one cycle", {31'h0, flush_pulse}, 0);
    wr(2'd0, 32'h0000_0003);
    chk("R8 flags update", {24'h0, mode_flags}, 32'h07);
    chk("R7 addseg sticky", {31'h0, mode_flags[1]}, 1);
    wr(2'd1, 32'h1234_5000);
    chk("R11 cr3 stored", cr3_q, 32'h1234_5000);
    chk("R11 no flush pg off", {31'h0, flush_pulse}, 0);
    simd_cap = 0;
    wr(2'd2, 32'h200);
    chk("R10 fxsr gated", cr4_q, 0);
    simd_cap = 1;
    wr(2'd2, 32'h220);
    chk("R10 fxsr stored", cr4_q, 32'h220);
    chk("R10 osfxsr flag", {31'h0, mode_flags[7]}, 1);
    chk("R9 flush on pae", {31'h0, flush_pulse}, 1);
    wr(2'd2, 32'h221);
    chk("R9 no flush bit0", {31'h0, flush_pulse}, 0);
    wr(2'd3, 32'h500);
    chk("R12 efer lma protected", efer_q, 32'h100);
    wr(2'd2, 32'h200);
    wr(2'd0, 32'h8000_0001);
    chk("R5 refused cr0", cr0_q, 32'h13);
    chk("R5 refused flags", {24'h0, mode_flags}, 32'h87);
    chk("R5 refused no flush", {31'h0, flush_pulse}, 0);
    wr(2'd2, 32'h220);
    wr(2'd0, 32'h8000_0001);
    chk("R4 cr0", cr0_q, 32'h8000_0011);
    chk("R4 flags", {24'h0, mode_flags}, 32'hA3);
    chk("R4 efer", efer_q, 32'h500);
    wr(2'd1, 32'h00AB_C000);
    chk("R11 flush pg on", {31'h0, flush_pulse}, 1);
    wr(2'd0, 32'h0000_0001);
    chk("R6 flags", {24'h0, mode_flags}, 32'h83);
    chk("R6 efer", efer_q, 32'h100);
    chk("R6 trunc", {31'h0, pc_trunc_pulse}, 1);
    idle();
    chk("R13 trunc one cycle", {31'h0, pc_trunc_pulse}, 0);
    @(negedge clk);
    wr_en = 0; wr_sel = 2'd0; wr_data = 32'hFFFF_FFFF;
    idle();
    chk("R12 no write when idle", cr0_q, 32'h11);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h8000_0000);
    chk("R4 paging without lme", {24'h0, mode_flags}, 32'h82);
    chk("R4 cr0 pg only", cr0_q, 32'h8000_0010);
    wr(2'd0, 32'h8001_0000);
    chk("R3 flush on wp", {31'h0, flush_pulse}, 1);

    // Random phase compared every clock by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 3) != 0);
      wr_sel = 2'($urandom_range(0, 3));
      wr_data = $urandom;
      simd_cap = $urandom_range(0, 1) != 0;
      if ($urandom_range(0, 199) == 0) rst = 1; else rst = 0;
    end
    @(negedge clk);
    wr_en = 0; rst = 0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule